// File: doc/BRIEF.md
# Lane-Parallel Rounding Shift-Right Accumulator

This unit takes a 128-bit source vector and a 128-bit destination vector. It treats them as parallel lanes of 8, 16, 32 or 64 bits. Each source lane is shifted right by an immediate count, which can be anything from 1 up to the lane width. Signed lanes shift arithmetically and unsigned lanes shift logically.

Two options can be enabled together or separately:
- A rounding bias of half the weight of the last bit shifted out.
- A fused add of the shifted value into the matching destination lane, with wraparound.

The new destination vector appears on a registered output one clock after the request.

Three result modes are available. Full mode writes every lane. Half mode keeps the lower 64 bits and clears the upper 64. Scalar mode keeps only lane 0 and clears everything above it. The surrounding datapath owns instruction decode and register storage. It presents operands and control on a single valid strobe.

Rounding is exact at every lane width, including 64-bit lanes. A bias add that would overflow the lane still produces the correct quotient. This is done by adding the last bit shifted out instead of adding a bias before the shift.

Top module: `lane_shr_acc`

## Requirements
- R1: With `is_signed`=0, each lane of `result` is the source lane shifted right logically by `shamt`, with zeros entering from the top.
- R2: With `is_signed`=1, each lane is shifted right arithmetically, with copies of the lane's top bit entering from the top.
- R3: With `do_round`=1, each shifted lane is increased by bit (`shamt`-1) of the source lane. This equals adding 2^(`shamt`-1) before the shift.
- R4: For 64-bit lanes the rounding is exact: an unsigned all-ones lane shifted by 1 with rounding gives 0x8000_0000_0000_0000.
- R5: When `shamt` equals the lane width, the shifted value before rounding is 0 for unsigned lanes and the sign fill (all ones or all zeros) for signed lanes.
- R6: With `do_acc`=1, the rounded shifted lane is added to the matching `dst` lane modulo 2^lane-width, and no carry crosses a lane boundary.
- R7: With `mode`=1 (half), bits 127:64 of `result` are zero and the lower 64 bits follow R1 to R6.
- R8: With `mode`=2 (scalar), only lane 0 is computed and every bit above lane 0 is zero. `mode`=0 is full width.
- R9: `result` and `out_valid` update one clock after `in_valid` is high. While `in_valid` is low, `result` holds and `out_valid` is low.
- R10: While `rst_n` is low, `out_valid` and `result` are zero.

Lane size encoding: `lane_sz` 0, 1, 2 and 3 select 8, 16, 32 and 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| lane_sz | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| shamt | input | 7 | Right shift count, 1 to lane width |
| is_signed | input | 1 | 1: arithmetic shift, 0: logical shift |
| do_round | input | 1 | Add rounding bias |
| do_acc | input | 1 | Add into destination lane |
| mode | input | 2 | 0 full, 1 half, 2 scalar |
| src | input | 128 | Source vector |
| dst | input | 128 | Current destination vector |
| out_valid | output | 1 | `result` was loaded on the last edge |
| result | output | 128 | New destination vector |

## Verification
The checker assumes that every accepted request carries a legal shift count, from 1 up to the selected lane width, and a mode code other than 3. The unit's output is undefined outside those ranges, so the checker flags them as input violations rather than design faults. Every table row and directed test in the bench stays inside these ranges. The rows cover the extreme counts on purpose: 1 on 64-bit lanes, and exactly the lane width on 8-bit and 32-bit lanes. Between requests `in_valid` is held low with different operands driven, so the hold property is exercised against changing inputs.

// File: rtl/lane_shr_pkg.sv
package lane_shr_pkg;
  localparam int unsigned VEC_W      = 128;
  localparam int unsigned MAX_LANE_W = 64;
  localparam int unsigned SZ_CNT     = 4;
  localparam int unsigned SH_W       = $clog2(MAX_LANE_W) + 1;

  localparam logic [1:0] MODE_FULL   = 2'd0;
  localparam logic [1:0] MODE_HALF   = 2'd1;
  localparam logic [1:0] MODE_SCALAR = 2'd2;
endpackage

// File: rtl/lsra_lane.sv
// One lane: shift right, add last-bit-out rounding, optional accumulate.
module lsra_lane #(
  parameter int unsigned W    = 8,
  parameter int unsigned SH_W = 7
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    d,
  input  logic [SH_W-1:0] sh,
  input  logic            sgn,
  input  logic            rnd,
  input  logic            acc,
  output logic [W-1:0]    y
);
  logic signed [W:0] ext;
  logic [W-1:0]      shifted;
  logic [W-1:0]      pick;
  logic              rbit;

  always_comb begin
    // one guard bit lets a shift by the full width yield zero or sign fill
    ext     = {sgn & a[W-1], a};
    shifted = W'(ext >>> sh);
    // rounding via the last bit shifted out: exact, never overflows the lane
    pick    = W'(1) << (sh - SH_W'(1));
    rbit    = rnd & (|(a & pick));
    y       = shifted + W'(rbit) + (acc ? d : '0);
  end
endmodule

// File: rtl/lsra_bank.sv
// All lanes of one lane width across the vector.
module lsra_bank #(
  parameter int unsigned W     = 8,
  parameter int unsigned VEC_W = 128,
  parameter int unsigned SH_W  = 7
) (
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] dst,
  input  logic [SH_W-1:0]  sh,
  input  logic             sgn,
  input  logic             rnd,
  input  logic             acc,
  output logic [VEC_W-1:0] y
);
  localparam int unsigned LANES = VEC_W / W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lsra_lane #(.W(W), .SH_W(SH_W)) u_lane (
      .a   (src[i*W +: W]),
      .d   (dst[i*W +: W]),
      .sh  (sh),
      .sgn (sgn),
      .rnd (rnd),
      .acc (acc),
      .y   (y[i*W +: W])
    );
  end
endmodule

// File: rtl/lane_shr_acc.sv
module lane_shr_acc
  import lane_shr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        lane_sz,
  input  logic [SH_W-1:0]   shamt,
  input  logic              is_signed,
  input  logic              do_round,
  input  logic              do_acc,
  input  logic [1:0]        mode,
  input  logic [VEC_W-1:0]  src,
  input  logic [VEC_W-1:0]  dst,
  output logic              out_valid,
  output logic [VEC_W-1:0]  result
);
  localparam int unsigned HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] bank_y [SZ_CNT];
  logic [VEC_W-1:0] sel_y;
  logic [VEC_W-1:0] keep;
  logic [VEC_W-1:0] result_d;
  logic             valid_d;

  for (genvar g = 0; g < SZ_CNT; g++) begin : g_bank
    lsra_bank #(.W(8 << g), .VEC_W(VEC_W), .SH_W(SH_W)) u_bank (
      .src (src),
      .dst (dst),
      .sh  (shamt),
      .sgn (is_signed),
      .rnd (do_round),
      .acc (do_acc),
      .y   (bank_y[g])
    );
  end

  // next-state: pick lane width, then clear lanes outside the mode
  always_comb begin
    sel_y = bank_y[lane_sz];
    unique case (mode)
      MODE_HALF:   keep = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
      MODE_SCALAR: keep = {VEC_W{1'b1}} >> (VEC_W - (32'd8 << lane_sz));
      default:     keep = {VEC_W{1'b1}};
    endcase
    result_d = sel_y & keep;
    valid_d  = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= valid_d;
      if (in_valid) begin
        result <= result_d;
      end
    end
  end
endmodule

// File: rtl/lane_shr_acc_chk.sv
module lane_shr_acc_chk
  import lane_shr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       lane_sz,
  input logic [SH_W-1:0]  shamt,
  input logic             is_signed,
  input logic             do_round,
  input logic             do_acc,
  input logic [1:0]       mode,
  input logic             out_valid,
  input logic [VEC_W-1:0] result
);
  logic [SH_W-1:0] esz;
  assign esz = SH_W'(8) << lane_sz;

  // input legality assumed by all other properties
  p_legal_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (shamt >= SH_W'(1)) && (shamt <= esz) && (mode != 2'd3));

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  p_half_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_HALF) |=> result[VEC_W-1:VEC_W/2] == '0);

  p_scalar_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_SCALAR && lane_sz == 2'd0) |=> result[VEC_W-1:8] == '0);

  p_full_width_unsigned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_signed && !do_round && !do_acc && shamt == esz) |=> result == '0);
endmodule

bind lane_shr_acc lane_shr_acc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .lane_sz   (lane_sz),
  .shamt     (shamt),
  .is_signed (is_signed),
  .do_round  (do_round),
  .do_acc    (do_acc),
  .mode      (mode),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/tb_lane_shr_acc.sv
module tb_lane_shr_acc;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic [1:0]   sz;
    logic         sgn;
    logic         rnd;
    logic         acc;
    logic [1:0]   md;
    logic [6:0]   sh;
    logic [127:0] s;
    logic [127:0] d;
    logic [127:0] e;
  } vec_t;

  // sz, sgn, rnd, acc, mode, shamt, src, dst, expected
  localparam vec_t VECS [NV] = '{
    // R1 logical 8-bit
    '{2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 7'd4, {16{8'hF0}}, {16{8'hAA}}, {16{8'h0F}}},
    // R2 arithmetic 16-bit
    '{2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 7'd4, {8{16'h8000}}, '0, {8{16'hF800}}},
    // R3 unsigned rounding 32-bit: 12>>3=1, bit2 set -> 2
    '{2'd2, 1'b0, 1'b1, 1'b0, 2'd0, 7'd3, {4{32'h0000_000C}}, '0, {4{32'h0000_0002}}},
    // R3 signed rounding: -2 >> 2 = -1, bit1 set -> 0
    '{2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 7'd2, {8{16'hFFFE}}, '0, '0},
    // R4 64-bit carry kept
    '{2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 7'd1, {2{64'hFFFF_FFFF_FFFF_FFFF}}, '0, {2{64'h8000_0000_0000_0000}}},
    // R5 signed full-width shift gives sign fill
    '{2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 7'd8, {8{16'h7F80}}, '0, {8{16'h00FF}}},
    // R5 signed full-width with rounding: -1 + 1 = 0
    '{2'd2, 1'b1, 1'b1, 1'b0, 2'd0, 7'd32, {4{32'h8000_0000}}, '0, '0},
    // R5 unsigned full-width with rounding: 0 + 1
    '{2'd2, 1'b0, 1'b1, 1'b0, 2'd0, 7'd32, {4{32'h8000_0000}}, '0, {4{32'h0000_0001}}},
    // R6 accumulate wraps per lane, no carry across lanes
    '{2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 7'd1, {8{16'h0004}}, {8{16'hFFFF}}, {8{16'h0001}}},
    // R6 signed round+acc: 0x81 -> 0xC1, +0x40 -> 0x01
    '{2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 7'd1, {16{8'h81}}, {16{8'h40}}, {16{8'h01}}},
    // R7 half mode clears upper 64
    '{2'd2, 1'b0, 1'b0, 1'b0, 2'd1, 7'd4, {4{32'h0000_0100}}, '0, {64'h0, {2{32'h0000_0010}}}},
    // R8 scalar 64-bit signed
    '{2'd3, 1'b1, 1'b0, 1'b0, 2'd2, 7'd8, {64'h1234_5678_9ABC_DEF0, 64'hFF00_0000_0000_0000},
      {2{64'h5555_5555_5555_5555}}, {64'h0, 64'hFFFF_0000_0000_0000}},
    // R8 scalar 8-bit with accumulate
    '{2'd0, 1'b0, 1'b0, 1'b1, 2'd2, 7'd2, {16{8'h10}}, {16{8'h05}}, {120'h0, 8'h09}}
  };

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   lane_sz;
  logic [6:0]   shamt;
  logic         is_signed;
  logic         do_round;
  logic         do_acc;
  logic [1:0]   mode;
  logic [127:0] src;
  logic [127:0] dst;
  logic         out_valid;
  logic [127:0] result;

  int n_chk;
  int n_bad;
  bit done;

  lane_shr_acc dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .lane_sz   (lane_sz),
    .shamt     (shamt),
    .is_signed (is_signed),
    .do_round  (do_round),
    .do_acc    (do_acc),
    .mode      (mode),
    .src       (src),
    .dst       (dst),
    .out_valid (out_valid),
    .result    (result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    in_valid  = 1'b1;
    lane_sz   = v.sz;
    is_signed = v.sgn;
    do_round  = v.rnd;
    do_acc    = v.acc;
    mode      = v.md;
    shamt     = v.sh;
    src       = v.s;
    dst       = v.d;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done = 1'b0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    lane_sz = 2'd0;
    shamt = 7'd1;
    is_signed = 1'b0;
    do_round = 1'b0;
    do_acc = 1'b0;
    mode = 2'd0;
    src = '0;
    dst = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 result", result, '0);
    check("R10 out_valid", {127'h0, out_valid}, 128'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("vector %0d result", i), result, VECS[i].e);
      check("R9 out_valid after request", {127'h0, out_valid}, 128'h1);
    end

    // R9 hold: change operands with in_valid low
    src = {128{1'b1}};
    dst = {128{1'b1}};
    shamt = 7'd1;
    mode = 2'd0;
    @(negedge clk);
    check("R9 hold result", result, VECS[NV-1].e);
    check("R9 out_valid idle", {127'h0, out_valid}, 128'h0);

    // R10 mid-run reset clears loaded result
    apply(VECS[0]);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears result", result, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 contrast: signed 64-bit all-ones shifted by 1 with rounding -> 0
    apply('{2'd3, 1'b1, 1'b1, 1'b0, 2'd0, 7'd1, {128{1'b1}}, '0, '0});
    check("R4 signed 64-bit round", result, '0);

    // R5 unsigned 64-bit full-width shift without rounding -> 0
    apply('{2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 7'd64, {128{1'b1}}, '0, '0});
    check("R5 unsigned 64-bit width shift", result, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule